// File: doc/BRIEF.md
# SHA Message Padder and Block Formatter

This block sits in front of a SHA compression core. It takes message data one byte at a time and packs it into 32-bit words. It cuts the word stream into hash-input blocks and, at the end of a message, produces the standard padding tail. The core takes each word through a valid/ready handshake. Two side flags go with every word: one marks the first block of a message, and the other marks the last word of a block. From these the core can tell when to load its initial chaining value and when a block is complete.

A start pulse opens a message and latches the framing mode.
- Mode 0 gives the narrow framing used by SHA-1 and SHA-256: 64-byte blocks and a 64-bit length field.
- Mode 1 gives the wide framing used by SHA-384 and SHA-512: 128-byte blocks and a 128-bit length field.

While bytes arrive, the block counts them in a counter split into a low half and a high half. When the final strobe comes, it appends the marker byte, the zero fill and the big-endian bit length. This tail can take one block or two. A single-cycle done pulse follows the hand-off of the very last padded word.

Top module: `sha_msg_padder`

## Requirements
- R1: Until the first start pulse, and after each finished message until the next start pulse, `byte_ready_o` stays low and no word is produced. A start pulse clears the byte count, the block fill position, the first-block flag and any partly packed word, and in the cycle after a start `word_valid_o` is low. The frame mode is taken from `mode_i` only in the start cycle; later changes of `mode_i` have no effect on the message.
- R2: Bytes are packed big-endian: the earliest byte of each group of four lands in bits 31:24 of `word_o`. A block is 16 words in mode 0 and 32 words in mode 1.
- R3: While `word_valid_o` is high and `word_ready_i` is low, `word_o`, `word_first_o` and `word_eob_o` do not change and `word_valid_o` stays high.
- R4: `word_first_o` is 1 on every word of the first block of a message and 0 on every word of each later block.
- R5: `word_eob_o` is 1 exactly on the last word of each block (word 15 in mode 0, word 31 in mode 1).
- R6: A final strobe (`final_i` high while a message is open) ends the message. Any byte offered in the same cycle is not taken. The byte value 0x80 is placed directly after the last message byte.
- R7: Zero bytes follow the 0x80 byte up to the start of the length field at the end of a block. The tail fits in the current block when the free bytes left in it are at least the length-field size plus one. Otherwise a second block is emitted.
- R8: The length field holds the message length in bits (byte count times eight), most significant byte first. The field is 8 bytes in mode 0 and 16 bytes in mode 1. In the 16-byte field, the upper half carries the high count half shifted left by three, ORed with the top three bits of the low half.
- R9: The byte count is kept as two halves of `HALF_W` bits. When the low half wraps, a carry enters the high half, and this carry shows in the emitted length field.
- R10: `done_o` pulses for exactly one cycle, in the cycle after the last padded word is accepted. `byte_ready_o` is low in that cycle, and bytes offered afterwards are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a new message; clears all counters |
| mode_i | input | 1 | Frame mode, sampled with start (0: 64-byte blocks, 1: 128-byte blocks) |
| byte_valid_i | input | 1 | Message byte offered |
| byte_i | input | 8 | Message byte |
| byte_ready_o | output | 1 | Byte accepted when high together with valid |
| final_i | input | 1 | Ends the open message and starts padding |
| word_valid_o | output | 1 | Output word valid |
| word_o | output | 32 | Output word, earliest byte in the top bits |
| word_first_o | output | 1 | Word belongs to the first block of the message |
| word_eob_o | output | 1 | Last word of a block |
| word_ready_i | input | 1 | Downstream takes the word |
| done_o | output | 1 | Pulse after the last padded word is taken |

## Verification
Some properties are checked by assertion on every cycle:
- the word and its flags hold steady while the downstream stalls;
- a start always leaves the output empty;
- `done_o` is a lone pulse that directly follows the hand-off of a block-ending word, with byte intake already closed.

Other behaviour can only be shown by the bench's scenarios:
- the padding content, meaning the 0x80 placement, the one-block versus two-block boundary at 55/56 and 111/112 bytes, and the big-endian length bytes;
- the first-block flag across multi-block messages;
- the latching of the mode;
- the low-to-high carry of the count.

The carry is exercised by a second instance with narrow count halves that runs alongside the default one.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MSG  = 2'd1,
        ST_PAD  = 2'd2
    } pad_state_e;

    typedef enum logic {
        FRAME_64  = 1'b0,
        FRAME_128 = 1'b1
    } frame_e;

    typedef struct packed {
        logic first;   // word is part of the first block
        logic eob;     // word closes a block
        logic last;    // word closes the padded message
    } word_tag_t;

    localparam int FILL_W = 7;   // enough for positions 0..127

    function automatic logic [7:0] blk_bytes(frame_e f);
        return (f == FRAME_128) ? 8'd128 : 8'd64;
    endfunction

    function automatic logic [7:0] len_bytes(frame_e f);
        return (f == FRAME_128) ? 8'd16 : 8'd8;
    endfunction

endpackage

// File: rtl/sha_len_ctr.sv
module sha_len_ctr #(
    parameter int HALF_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [HALF_W-1:0] cnt_lo,
    output logic [HALF_W-1:0] cnt_hi
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (inc) begin
            cnt_lo <= cnt_lo + 1'b1;
            if (&cnt_lo) begin
                cnt_hi <= cnt_hi + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sha_pad_src.sv
module sha_pad_src
    import sha_pad_pkg::*;
#(
    parameter int HALF_W = 64
) (
    input  frame_e              frame,
    input  logic [FILL_W-1:0]   fill,
    input  logic                first_pad,
    input  logic                in_last_blk,
    input  logic [HALF_W-1:0]   len_lo,
    input  logic [HALF_W-1:0]   len_hi,
    output logic [7:0]          pad_byte
);
    localparam int BL_W   = 2 * HALF_W;
    localparam int WIDE_W = 128;

    logic [BL_W-1:0]   bit_len;
    logic [WIDE_W-1:0] bit_len_wide;
    logic [7:0]        blk, lenb, fstart, k;
    logic [8:0]        sh;
    logic              in_field;
    logic [7:0]        field_byte;

    always_comb begin
        // bit count of the message, top three bits of the high half drop out
        bit_len      = {len_hi, len_lo} << 3;
        bit_len_wide = WIDE_W'(bit_len);
        blk          = blk_bytes(frame);
        lenb         = len_bytes(frame);
        fstart       = blk - lenb;
        k            = {1'b0, fill} - fstart;
        in_field     = in_last_blk && ({1'b0, fill} >= fstart);
        sh           = {1'b0, lenb - 8'd1 - k} << 3;
        field_byte   = 8'(bit_len_wide >> sh);
        if (first_pad) begin
            pad_byte = 8'h80;
        end else if (in_field) begin
            pad_byte = field_byte;
        end else begin
            pad_byte = 8'h00;
        end
    end
endmodule

// File: rtl/sha_word_packer.sv
module sha_word_packer
    import sha_pad_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  word_tag_t   in_tag,
    output logic        in_ready,
    output logic        out_valid,
    output logic [31:0] out_word,
    output word_tag_t   out_tag,
    input  logic        out_ready
);
    logic [1:0]  bcnt;
    logic [31:0] wbuf;
    logic        take;
    logic        fire;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;
    assign fire     = out_valid && out_ready;
    assign out_word = wbuf;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bcnt      <= '0;
            wbuf      <= '0;
            out_valid <= 1'b0;
            out_tag   <= '0;
        end else begin
            if (fire) begin
                out_valid <= 1'b0;
            end
            if (take) begin
                wbuf <= {wbuf[23:0], in_byte};
                bcnt <= bcnt + 2'd1;
                if (bcnt == 2'd3) begin
                    out_valid <= 1'b1;
                    out_tag   <= in_tag;
                end
            end
        end
    end
endmodule

// File: rtl/sha_msg_padder.sv
module sha_msg_padder
    import sha_pad_pkg::*;
#(
    parameter int HALF_W = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        mode_i,
    input  logic        byte_valid_i,
    input  logic [7:0]  byte_i,
    output logic        byte_ready_o,
    input  logic        final_i,
    output logic        word_valid_o,
    output logic [31:0] word_o,
    output logic        word_first_o,
    output logic        word_eob_o,
    input  logic        word_ready_i,
    output logic        done_o
);
    pad_state_e        st;
    frame_e            frame_q;
    logic [FILL_W-1:0] fill;
    logic              first_blk;
    logic              pad_first;
    logic              last_blk;

    logic [HALF_W-1:0] cnt_lo, cnt_hi;
    logic [7:0]        pad_byte;
    logic              pk_in_ready;
    logic              msg_take, pad_take, take;
    logic              blk_end;
    logic [7:0]        blk, lenb, free_b;
    logic              tail_fits;
    word_tag_t         in_tag, out_tag;
    logic [7:0]        pk_byte;

    always_comb begin
        blk          = blk_bytes(frame_q);
        lenb         = len_bytes(frame_q);
        free_b       = blk - {1'b0, fill};
        tail_fits    = free_b >= (lenb + 8'd1);
        blk_end      = ({1'b0, fill} == (blk - 8'd1));
        byte_ready_o = (st == ST_MSG) && pk_in_ready;
        msg_take     = byte_valid_i && byte_ready_o && !final_i && !start_i;
        pad_take     = (st == ST_PAD) && pk_in_ready && !start_i;
        take         = msg_take || pad_take;
        pk_byte      = (st == ST_PAD) ? pad_byte : byte_i;
        in_tag.first = first_blk;
        in_tag.eob   = blk_end;
        in_tag.last  = (st == ST_PAD) && last_blk && blk_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            frame_q   <= FRAME_64;
            fill      <= '0;
            first_blk <= 1'b0;
            pad_first <= 1'b0;
            last_blk  <= 1'b0;
        end else if (start_i) begin
            st        <= ST_MSG;
            frame_q   <= frame_e'(mode_i);
            fill      <= '0;
            first_blk <= 1'b1;
            pad_first <= 1'b0;
            last_blk  <= 1'b0;
        end else begin
            if ((st == ST_MSG) && final_i) begin
                st        <= ST_PAD;
                pad_first <= 1'b1;
                last_blk  <= tail_fits;
            end
            if (take) begin
                fill <= blk_end ? '0 : fill + 1'b1;
                if (blk_end) begin
                    first_blk <= 1'b0;
                end
            end
            if (pad_take) begin
                pad_first <= 1'b0;
                if (blk_end) begin
                    last_blk <= 1'b1;
                    if (last_blk) begin
                        st <= ST_IDLE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
        end else begin
            done_o <= !start_i && word_valid_o && word_ready_i && out_tag.last;
        end
    end

    sha_len_ctr #(.HALF_W(HALF_W)) len_ctr_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (start_i),
        .inc    (msg_take),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi)
    );

    sha_pad_src #(.HALF_W(HALF_W)) pad_src_i (
        .frame       (frame_q),
        .fill        (fill),
        .first_pad   (pad_first),
        .in_last_blk (last_blk),
        .len_lo      (cnt_lo),
        .len_hi      (cnt_hi),
        .pad_byte    (pad_byte)
    );

    sha_word_packer packer_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (start_i),
        .in_valid  (take),
        .in_byte   (pk_byte),
        .in_tag    (in_tag),
        .in_ready  (pk_in_ready),
        .out_valid (word_valid_o),
        .out_word  (word_o),
        .out_tag   (out_tag),
        .out_ready (word_ready_i)
    );

    assign word_first_o = out_tag.first;
    assign word_eob_o   = out_tag.eob;

endmodule

// File: rtl/sha_msg_padder_chk.sv
module sha_msg_padder_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        byte_ready_o,
    input logic        word_valid_o,
    input logic [31:0] word_o,
    input logic        word_first_o,
    input logic        word_eob_o,
    input logic        word_ready_i,
    input logic        done_o
);
    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && !word_ready_i && !start_i) |=>
            (word_valid_o && $stable(word_o) && $stable(word_first_o) && $stable(word_eob_o)));

    // R1
    start_flush_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!word_valid_o && !done_o));

    // R10
    done_origin_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(word_valid_o && word_ready_i && word_eob_o));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10
    done_closed_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !byte_ready_o);

endmodule

bind sha_msg_padder sha_msg_padder_chk chk_i (.*);

// File: tb/sha_msg_padder_tb.sv
`timescale 1ns/1ps
module sha_msg_padder_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        start_i = 0, mode_i = 0, byte_valid_i = 0, final_i = 0, word_ready_i = 0;
    logic [7:0]  byte_i = 0;
    logic        a_bready, a_wvalid, a_first, a_eob, a_done;
    logic [31:0] a_word;
    logic        c_bready, c_wvalid, c_first, c_eob, c_done;
    logic [31:0] c_word;

    sha_msg_padder dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .byte_ready_o(a_bready),
        .final_i(final_i), .word_valid_o(a_wvalid), .word_o(a_word),
        .word_first_o(a_first), .word_eob_o(a_eob), .word_ready_i(word_ready_i),
        .done_o(a_done));

    // narrow count halves so the low-to-high carry is reachable
    sha_msg_padder #(.HALF_W(8)) dut_c (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .byte_ready_o(c_bready),
        .final_i(final_i), .word_valid_o(c_wvalid), .word_o(c_word),
        .word_first_o(c_first), .word_eob_o(c_eob), .word_ready_i(word_ready_i),
        .done_o(c_done));

    int n_chk = 0;
    int n_err = 0;
    int tick  = 0;
    logic [34:0] q_a[$];
    logic [34:0] q_c[$];
    logic exp_done_a = 0, exp_done_c = 0;
    logic saw_done = 0, byte_acc = 0;
    int cur_mode = 0, cur_len = 0, cur_seed = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] msg_byte(int i, int seed);
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction

    task automatic load_exp(ref logic [34:0] q[$], input int mode, input int len,
                            input int seed, input int halfw);
        int blk, lenb, nw, wpb;
        logic [7:0] b[$];
        logic [127:0] bits;
        blk  = mode ? 128 : 64;
        lenb = mode ? 16 : 8;
        for (int i = 0; i < len; i++) b.push_back(msg_byte(i, seed));
        b.push_back(8'h80);
        while ((b.size() % blk) != (blk - lenb)) b.push_back(8'h00);
        bits = 128'(len) << 3;
        if (halfw < 64) bits = bits & ((128'd1 << (2 * halfw)) - 128'd1);
        for (int k = 0; k < lenb; k++) b.push_back(8'(bits >> (8 * (lenb - 1 - k))));
        nw  = b.size() / 4;
        wpb = blk / 4;
        for (int w = 0; w < nw; w++) begin
            q.push_back({(w == nw - 1), (w < wpb), ((w % wpb) == wpb - 1),
                         b[4*w], b[4*w+1], b[4*w+2], b[4*w+3]});
        end
    endtask

    // one cycle: inputs already set at a negedge
    task automatic step();
        logic [34:0] e;
        logic fa, fc;
        #1;
        byte_acc = byte_valid_i && a_bready && !final_i && !start_i;
        chk("R10 done pulse", 64'(a_done), 64'(exp_done_a));
        chk("R9 done pulse narrow", 64'(c_done), 64'(exp_done_c));
        if (a_done) saw_done = 1;
        fa = a_wvalid && word_ready_i;
        fc = c_wvalid && word_ready_i;
        exp_done_a = 0;
        exp_done_c = 0;
        if (fa) begin
            if (q_a.size() == 0) chk("R7 extra word", 64'(a_word), 64'hx);
            else begin
                e = q_a.pop_front();
                chk("R2 R6 R7 R8 word", 64'(a_word), 64'(e[31:0]));
                chk("R4 first flag", 64'(a_first), 64'(e[33]));
                chk("R5 eob flag", 64'(a_eob), 64'(e[32]));
                exp_done_a = e[34] && !start_i;
            end
        end
        if (fc) begin
            if (q_c.size() == 0) chk("R9 extra word", 64'(c_word), 64'hx);
            else begin
                e = q_c.pop_front();
                chk("R9 word narrow", 64'(c_word), 64'(e[31:0]));
                chk("R4 first flag narrow", 64'(c_first), 64'(e[33]));
                chk("R5 eob flag narrow", 64'(c_eob), 64'(e[32]));
                exp_done_c = e[34] && !start_i;
            end
        end
        if (start_i) begin
            q_a.delete();
            q_c.delete();
            load_exp(q_a, cur_mode, cur_len, cur_seed, 64);
            load_exp(q_c, cur_mode, cur_len, cur_seed, 8);
        end
        tick++;
        @(negedge clk);
    endtask

    task automatic run_msg(input int mode, input int len, input int seed, input int abort_at);
        int idx;
        int guard;
        logic fin;
        cur_mode = mode; cur_len = len; cur_seed = seed;
        saw_done = 0;
        start_i = 1; mode_i = mode[0]; byte_valid_i = 0; final_i = 0;
        word_ready_i = 1;
        step();
        start_i = 0;
        mode_i = ~mode[0];   // R1: must not affect the open message
        idx = 0; fin = 0; guard = 0;
        while (!saw_done && guard < 6000) begin
            if (abort_at >= 0 && idx >= abort_at) break;
            word_ready_i = ((tick % 5) != 3);
            final_i = 0;
            byte_valid_i = 0;
            if (idx < len) begin
                byte_valid_i = ((tick % 7) != 2);
                byte_i = msg_byte(idx, seed);
            end else if (!fin) begin
                final_i = 1;
                byte_valid_i = 1;   // R6: byte offered with final is not taken
                byte_i = 8'hEE;
                fin = 1;
            end
            step();
            if (byte_acc) idx++;
            guard++;
        end
        final_i = 0; byte_valid_i = 0;
        if (abort_at < 0) begin
            chk("R10 done seen", 64'(saw_done), 64'd1);
            word_ready_i = 1;
            step();
            chk("R7 no words left", 64'(q_a.size()), 64'd0);
            chk("R9 no words left narrow", 64'(q_c.size()), 64'd0);
            for (int i = 0; i < 6; i++) begin
                byte_valid_i = 1; byte_i = 8'h5A; final_i = (i == 3);
                #1;
                chk("R10 ignored after done ready", 64'(a_bready), 64'd0);
                chk("R10 ignored after done word", 64'(a_wvalid), 64'd0);
                step();
            end
            byte_valid_i = 0; final_i = 0;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R10 run did not finish actual 0 expected 1");
        finish_run();
    end

    initial begin
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        byte_valid_i = 1; byte_i = 8'h11; word_ready_i = 1;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R1 no intake before start", 64'(a_bready), 64'd0);
            chk("R1 reset word valid", 64'(a_wvalid), 64'd0);
            chk("R1 reset done", 64'(a_done), 64'd0);
            @(negedge clk);
        end
        byte_valid_i = 0;

        run_msg(0, 0, 1, -1);
        run_msg(0, 3, 2, -1);
        run_msg(0, 55, 3, -1);    // R7 tail just fits
        run_msg(0, 56, 4, -1);    // R7 tail spills
        run_msg(0, 64, 5, -1);
        run_msg(0, 119, 6, -1);
        run_msg(0, 120, 7, -1);
        run_msg(1, 0, 8, -1);
        run_msg(1, 111, 9, -1);   // R7 wide fits
        run_msg(1, 112, 10, -1);  // R7 wide spills
        run_msg(1, 239, 11, -1);
        run_msg(1, 50, 12, 20);   // aborted by a new start (R1)
        run_msg(0, 10, 13, -1);
        run_msg(1, 300, 14, -1);  // R9 carry in narrow instance
        run_msg(0, 300, 15, -1);
        finish_run();
    end

endmodule